// File: doc/BRIEF.md
# Half-Precision Round-to-Integral Unit

This unit takes a 16-bit binary floating-point operand and rounds it to an integral value. The result stays in the same 16-bit floating-point format. The rounding direction comes from a 3-bit mode supplied with each operation. A variant select chooses between two behaviours: a quiet form that never reports inexact, and a signalling form that reports inexact whenever rounding changed the value.

The datapath is combinational and is captured in one register stage. Results, invalid and inexact appear one clock after the inputs are presented. The flags are per operation. Accumulating them into a status register is left to the surrounding pipeline.

Special operands bypass the rounding logic:
- Zeros, infinities and values that are already integral pass through untouched.
- NaNs are returned as they are and raise invalid.
- An unsupported rounding mode produces the canonical quiet NaN.

Top module: `hround_unit`

## Requirements
- R1: An operand that is ±0 or ±infinity (exponent field 31 with zero fraction) is returned bit-for-bit, with invalid and inexact both low.
- R2: A NaN operand (exponent field 31, fraction non-zero) is returned bit-for-bit with invalid high and inexact low.
- R3: The rounding mode encodings are 0 nearest-even, 1 toward zero, 2 toward minus infinity, 3 toward plus infinity and 4 nearest with ties away from zero. In mode 0 an exact half rounds to the even neighbour, so 2.5 gives 2.0 (0x4000) and 1.5 gives 2.0.
- R4: With the signalling select (nx_en_i=1), inexact is high exactly when the result differs from a non-NaN operand under a supported mode.
- R5: With the quiet select (nx_en_i=0), inexact is never raised.
- R6: An operand whose exponent field is 25 or more (magnitude of 1024 or more) and not 31 is already integral and is returned unchanged with no flags.
- R7: An operand with magnitude below 1.0, subnormals included, becomes a zero or 1.0 carrying the operand's sign, chosen by the mode. Such an operand never raises invalid.
- R8: A mode value of 5, 6 or 7 yields 0x7E00 with invalid high and inexact low, whatever the operand.
- R9: The result and flags are registered with a latency of one cycle. While rst_ni is low they read zero.
- R10: When rounding carries out of the significand, the exponent increments. For example 1023.5 (0x63FF) rounds to 1024 (0x6400) in mode 0, and to 1023 (0x63FE) in mode 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 16 | Half-precision operand |
| rm_i | input | 3 | Rounding mode |
| nx_en_i | input | 1 | 1 selects the inexact-signalling variant |
| res_o | output | 16 | Rounded result |
| inv_o | output | 1 | Invalid flag |
| nx_o | output | 1 | Inexact flag |

## Verification
Random operands cover every exponent field evenly, and each result is compared with a reference built on real arithmetic. That spread separates the pass-through classes (zero, infinity, NaN, large integral), the below-one path and the general fractional path. Random modes, including unsupported codes, confirm that each direction treats positive and negative values differently. Directed exact halves (0.5, 1.5, 2.5) separate nearest-even from ties-away. The value 1023.5 exercises the exponent carry, and subnormals confirm the below-one path raises no invalid. The quiet and signalling selects are each applied to the same changing values, so the flag gating is shown independently of the rounding itself.

// File: rtl/hround_pkg.sv
package hround_pkg;
  localparam int FP_W    = 16;
  localparam int EXP_W   = 5;
  localparam int MAN_W   = 10;
  localparam int RM_W    = 3;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam int INT_EXP = BIAS + MAN_W;   // first biased exponent with no fraction bits
  localparam int SIG_W   = MAN_W + 1;
  localparam logic [FP_W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  typedef enum logic [RM_W-1:0] {
    RM_RNE = 3'd0,
    RM_RTZ = 3'd1,
    RM_RDN = 3'd2,
    RM_RUP = 3'd3,
    RM_RMM = 3'd4
  } rm_e;

  typedef struct packed {
    logic bad_rm;
    logic nan;
    logic inf;
    logic zero;
    logic whole;
    logic below_one;
  } cls_t;
endpackage

// File: rtl/hround_class.sv
module hround_class
  import hround_pkg::*;
(
  input  logic [FP_W-1:0] op_i,
  input  logic [RM_W-1:0] rm_i,
  output cls_t            cls_o
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             exp_all1;
  logic             man_nz;

  assign exp_f    = op_i[FP_W-2 -: EXP_W];
  assign man_f    = op_i[MAN_W-1:0];
  assign exp_all1 = (exp_f == EXP_W'(EXP_MAX));
  assign man_nz   = |man_f;

  assign cls_o.bad_rm    = (rm_i > RM_RMM);
  assign cls_o.nan       = exp_all1 & man_nz;
  assign cls_o.inf       = exp_all1 & ~man_nz;
  assign cls_o.zero      = (exp_f == '0) & ~man_nz;
  assign cls_o.whole     = (exp_f >= EXP_W'(INT_EXP)) & ~exp_all1;
  assign cls_o.below_one = (exp_f < EXP_W'(BIAS)) & ~cls_o.zero;
endmodule

// File: rtl/hround_incr.sv
module hround_incr
  import hround_pkg::*;
(
  input  logic [RM_W-1:0] rm_i,
  input  logic            sign_i,
  input  logic            lsb_i,
  input  logic            guard_i,
  input  logic            sticky_i,
  output logic            inc_o
);
  logic lost;
  assign lost = guard_i | sticky_i;

  always_comb begin
    unique case (rm_i)
      RM_RNE:  inc_o = guard_i & (sticky_i | lsb_i);
      RM_RTZ:  inc_o = 1'b0;
      RM_RDN:  inc_o = sign_i & lost;
      RM_RUP:  inc_o = ~sign_i & lost;
      RM_RMM:  inc_o = guard_i;
      default: inc_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/hround_mid.sv
// Rounds operands with BIAS <= exponent < INT_EXP (1.0 <= |x| < 2^MAN_W).
module hround_mid
  import hround_pkg::*;
(
  input  logic [RM_W-1:0]  rm_i,
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [MAN_W-1:0] man_i,
  output logic [EXP_W-1:0] exp_o,
  output logic [MAN_W-1:0] man_o,
  output logic             lost_o
);
  logic [EXP_W-1:0] fb;
  logic [SIG_W-1:0] sig, int_part, sh_g, lo_mask;
  logic             guard, sticky, inc;
  logic [SIG_W:0]   rsum, rsig;

  assign fb       = EXP_W'(INT_EXP) - exp_i;   // count of fraction bits, 1..MAN_W
  assign sig      = {1'b1, man_i};
  assign int_part = sig >> fb;
  assign sh_g     = sig >> (fb - EXP_W'(1));
  assign guard    = sh_g[0];
  assign lo_mask  = (SIG_W'(1) << (fb - EXP_W'(1))) - SIG_W'(1);
  assign sticky   = |(sig & lo_mask);

  hround_incr u_incr (
    .rm_i     (rm_i),
    .sign_i   (sign_i),
    .lsb_i    (int_part[0]),
    .guard_i  (guard),
    .sticky_i (sticky),
    .inc_o    (inc)
  );

  assign rsum = {1'b0, int_part} + {{SIG_W{1'b0}}, inc};
  assign rsig = rsum << fb;

  // carry past the hidden bit bumps the exponent
  assign exp_o  = rsig[SIG_W] ? exp_i + EXP_W'(1) : exp_i;
  assign man_o  = rsig[SIG_W] ? rsig[SIG_W-1:1] : rsig[SIG_W-2:0];
  assign lost_o = guard | sticky;
endmodule

// File: rtl/hround_unit.sv
module hround_unit
  import hround_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FP_W-1:0] op_i,
  input  logic [RM_W-1:0] rm_i,
  input  logic            nx_en_i,
  output logic [FP_W-1:0] res_o,
  output logic            inv_o,
  output logic            nx_o
);
  cls_t             cls;
  logic             sign;
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             half_bit, small_st, small_inc;
  logic [EXP_W-1:0] mid_exp;
  logic [MAN_W-1:0] mid_man;
  logic             mid_lost;
  logic [FP_W-1:0]  res_d;
  logic             inv_d, chg_d;

  assign sign  = op_i[FP_W-1];
  assign exp_f = op_i[FP_W-2 -: EXP_W];
  assign man_f = op_i[MAN_W-1:0];

  hround_class u_class (
    .op_i  (op_i),
    .rm_i  (rm_i),
    .cls_o (cls)
  );

  // |x| < 1: integer part is 0, guard is the 0.5 weight
  assign half_bit = (exp_f == EXP_W'(BIAS - 1));
  assign small_st = half_bit ? (|man_f) : 1'b1;

  hround_incr u_small_incr (
    .rm_i     (rm_i),
    .sign_i   (sign),
    .lsb_i    (1'b0),
    .guard_i  (half_bit),
    .sticky_i (small_st),
    .inc_o    (small_inc)
  );

  hround_mid u_mid (
    .rm_i   (rm_i),
    .sign_i (sign),
    .exp_i  (exp_f),
    .man_i  (man_f),
    .exp_o  (mid_exp),
    .man_o  (mid_man),
    .lost_o (mid_lost)
  );

  always_comb begin
    res_d = op_i;
    inv_d = 1'b0;
    chg_d = 1'b0;
    if (cls.bad_rm) begin
      res_d = QNAN;
      inv_d = 1'b1;
    end else if (cls.nan) begin
      inv_d = 1'b1;
    end else if (cls.inf || cls.zero || cls.whole) begin
      res_d = op_i;
    end else if (cls.below_one) begin
      res_d = small_inc ? {sign, EXP_W'(BIAS), {MAN_W{1'b0}}} : {sign, {(FP_W-1){1'b0}}};
      chg_d = 1'b1;
    end else begin
      res_d = {sign, mid_exp, mid_man};
      chg_d = mid_lost;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o <= '0;
      inv_o <= 1'b0;
      nx_o  <= 1'b0;
    end else begin
      res_o <= res_d;
      inv_o <= inv_d;
      nx_o  <= nx_en_i & chg_d;
    end
  end
endmodule

// File: rtl/hround_chk.sv
module hround_chk
  import hround_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic [FP_W-1:0] op_i,
  input logic [RM_W-1:0] rm_i,
  input logic            nx_en_i,
  input logic [FP_W-1:0] res_o,
  input logic            inv_o,
  input logic            nx_o
);
  logic             past_ok;
  logic [EXP_W-1:0] e_in;
  logic             in_bad, in_nan, in_pass, in_whole;

  assign e_in     = op_i[FP_W-2 -: EXP_W];
  assign in_bad   = (rm_i > 3'd4);
  assign in_nan   = (e_in == EXP_W'(EXP_MAX)) && (op_i[MAN_W-1:0] != '0);
  assign in_pass  = (e_in == EXP_W'(EXP_MAX) && op_i[MAN_W-1:0] == '0) ||
                    (op_i[FP_W-2:0] == '0);
  assign in_whole = (e_in >= EXP_W'(INT_EXP)) && (e_in != EXP_W'(EXP_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_ZERO_INF_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(in_pass && !in_bad) |-> res_o == $past(op_i) && !inv_o && !nx_o); // R1
  AST_NAN_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(in_nan && !in_bad) |-> res_o == $past(op_i) && inv_o && !nx_o); // R2
  AST_NX_CHANGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(nx_en_i && !in_nan && !in_bad) |-> nx_o == (res_o != $past(op_i))); // R4
  AST_QUIET_NO_NX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(!nx_en_i) |-> !nx_o); // R5
  AST_WHOLE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(in_whole && !in_bad) |-> res_o == $past(op_i) && !inv_o && !nx_o); // R6
  AST_BAD_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && $past(in_bad) |-> res_o == 16'h7E00 && inv_o && !nx_o); // R8
  AST_INV_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && inv_o |-> $past(in_nan || in_bad)); // R7
endmodule

bind hround_unit hround_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .op_i    (op_i),
  .rm_i    (rm_i),
  .nx_en_i (nx_en_i),
  .res_o   (res_o),
  .inv_o   (inv_o),
  .nx_o    (nx_o)
);

// File: tb/sim_hround_unit.sv
module sim_hround_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op = '0;
  logic [2:0]  rm = '0;
  logic        nx_en = 1'b0;
  logic [15:0] res;
  logic        inv, nx;
  int          tests = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  hround_unit u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .op_i    (op),
    .rm_i    (rm),
    .nx_en_i (nx_en),
    .res_o   (res),
    .inv_o   (inv),
    .nx_o    (nx)
  );

  function automatic logic [15:0] int_to_h(logic s, int n);
    int p = 0;
    logic [15:0] fr;
    if (n == 0) return {s, 15'h0};
    for (int i = 0; i < 16; i++) if ((n >> i) != 0) p = i;
    if (p <= 10) fr = 16'((n << (10 - p)) & 32'h3FF);
    else         fr = 16'((n >> (p - 10)) & 32'h3FF);
    return {s, 5'(p + 15), fr[9:0]};
  endfunction

  // {result, invalid, inexact}
  function automatic logic [17:0] ref_model(logic [15:0] o, logic [2:0] m, logic en);
    logic       s = o[15];
    int         e = int'(o[14:10]);
    int         f = int'(o[9:0]);
    int         mant, k, n;
    real        a, fl, d;
    logic [15:0] r;
    if (m > 3'd4) return {16'h7E00, 1'b1, 1'b0};
    if (e == 31) return {o, (f != 0), 1'b0};
    if ((e == 0 && f == 0) || e >= 25) return {o, 1'b0, 1'b0};
    mant = (e == 0) ? f : 1024 + f;
    k    = (e == 0) ? 24 : 25 - e;
    a    = real'(mant);
    for (int i = 0; i < k; i++) a = a / 2.0;
    fl = $floor(a);
    d  = a - fl;
    case (m)
      3'd0: begin
        if (d > 0.5) n = $rtoi(fl) + 1;
        else if (d < 0.5) n = $rtoi(fl);
        else n = ($rtoi(fl) % 2 == 1) ? $rtoi(fl) + 1 : $rtoi(fl);
      end
      3'd1: n = $rtoi(fl);
      3'd2: n = s ? $rtoi($ceil(a)) : $rtoi(fl);
      3'd3: n = s ? $rtoi(fl) : $rtoi($ceil(a));
      default: n = (d >= 0.5) ? $rtoi(fl) + 1 : $rtoi(fl);
    endcase
    r = int_to_h(s, n);
    return {r, 1'b0, en && (r != o)};
  endfunction

  function automatic string tag_of(logic [15:0] o, logic [2:0] m, logic en);
    if (m > 3'd4) return "R8";
    if (o[14:10] == 5'h1F) return (o[9:0] != 0) ? "R2" : "R1";
    if (o[14:0] == 0) return "R1";
    if (o[14:10] >= 5'd25) return "R6";
    if (o[14:10] < 5'd15) return "R7";
    if (!en) return "R5";
    return "R4";
  endfunction

  task automatic check(string tag, logic [15:0] er, logic ei, logic en_x);
    tests++;
    if (res !== er || inv !== ei || nx !== en_x) begin
      fails++;
      $display("FAIL %s op=%h rm=%0d sel=%0b: got res=%h inv=%b nx=%b, exp res=%h inv=%b nx=%b",
               tag, op, rm, nx_en, res, inv, nx, er, ei, en_x);
    end
  endtask

  task automatic apply(logic [15:0] o, logic [2:0] m, logic en);
    @(negedge clk);
    op = o; rm = m; nx_en = en;
    @(negedge clk);
  endtask

  task automatic run(string tag, logic [15:0] o, logic [2:0] m, logic en);
    logic [17:0] ex;
    apply(o, m, en);
    ex = ref_model(o, m, en);
    check(tag, ex[17:2], ex[1], ex[0]);
  endtask

  task automatic run_fixed(string tag, logic [15:0] o, logic [2:0] m, logic en,
                           logic [15:0] er, logic ei, logic ex_nx);
    apply(o, m, en);
    check(tag, er, ei, ex_nx);
  endtask

  initial begin
    void'($urandom(32'd1234));
    op = 16'h3E00; rm = 3'd0; nx_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", 16'h0000, 1'b0, 1'b0);         // outputs held at zero in reset
    rst_n = 1'b1;

    run_fixed("R1", 16'h8000, 3'd3, 1'b1, 16'h8000, 1'b0, 1'b0);
    run_fixed("R1", 16'hFC00, 3'd0, 1'b1, 16'hFC00, 1'b0, 1'b0);
    run_fixed("R2", 16'h7C01, 3'd0, 1'b1, 16'h7C01, 1'b1, 1'b0);
    run_fixed("R3", 16'h4100, 3'd0, 1'b1, 16'h4000, 1'b0, 1'b1);  // 2.5 -> 2
    run_fixed("R3", 16'h3E00, 3'd0, 1'b1, 16'h4000, 1'b0, 1'b1);  // 1.5 -> 2
    run_fixed("R3", 16'h4100, 3'd4, 1'b1, 16'h4200, 1'b0, 1'b1);  // 2.5 -> 3 ties away
    run_fixed("R3", 16'h3800, 3'd0, 1'b1, 16'h0000, 1'b0, 1'b1);  // 0.5 -> +0
    run_fixed("R4", 16'h3C00, 3'd2, 1'b1, 16'h3C00, 1'b0, 1'b0);  // exact 1.0, no inexact
    run_fixed("R5", 16'h3E00, 3'd3, 1'b0, 16'h4000, 1'b0, 1'b0);
    run_fixed("R6", 16'h6401, 3'd3, 1'b1, 16'h6401, 1'b0, 1'b0);
    run_fixed("R7", 16'hB4CD, 3'd3, 1'b1, 16'h8000, 1'b0, 1'b1);  // -0.3 up -> -0
    run_fixed("R7", 16'hB4CD, 3'd2, 1'b1, 16'hBC00, 1'b0, 1'b1);  // -0.3 down -> -1
    run_fixed("R7", 16'h0001, 3'd3, 1'b1, 16'h3C00, 1'b0, 1'b1);  // subnormal up
    run_fixed("R7", 16'h8001, 3'd1, 1'b0, 16'h8000, 1'b0, 1'b0);
    run_fixed("R8", 16'h3C00, 3'd5, 1'b1, 16'h7E00, 1'b1, 1'b0);
    run_fixed("R8", 16'h7C01, 3'd7, 1'b0, 16'h7E00, 1'b1, 1'b0);
    run_fixed("R10", 16'h63FF, 3'd0, 1'b1, 16'h6400, 1'b0, 1'b1);
    run_fixed("R10", 16'h63FF, 3'd1, 1'b1, 16'h63FE, 1'b0, 1'b1);

    for (int i = 0; i < 4000; i++) begin
      logic [15:0] o;
      logic [2:0]  m;
      logic        en;
      o  = 16'($urandom);
      m  = ($urandom % 8 == 0) ? 3'(5 + $urandom % 3) : 3'($urandom % 5);
      en = 1'($urandom);
      run(tag_of(o, m, en), o, m, en);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got no completion, exp completion within limit");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule